// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Threshold Flags

This block is a single-clock FIFO for a small, power-of-two number of memory words. It has two read behaviours, and the choice is made while master reset is held. In standard mode a read request moves the oldest stored word onto the output register on the next clock edge. The flags in this mode report whether the FIFO holds any data and whether it has space. In fall-through mode the oldest word is moved to the output register without a read request. A read then consumes that word and brings the next one forward. The output register adds one word of storage, and every threshold moves up by one word.

Besides the data-available and space-available flags, the block drives three occupancy flags. Almost-empty compares occupancy against an empty offset. Almost-full compares it against a full offset. Half-full compares it against half the memory depth. All flags are registered. They change on the same clock edge as the occupancy count they describe, so downstream logic can use them directly as throttles.

Top module: `dmfifo_top`

## Requirements
- R1: The mode input `fwftSel` is captured only while `mRst` is high (0 = standard, 1 = fall-through). Changes on it at any other time do not affect behaviour.
- R2: While `mRst` is high the FIFO empties and `dataOut` clears to 0. After reset, `rdAvail`=0, `wrAvail`=1, `almostEmpty`=1, `almostFull`=0 and `halfFull`=0.
- R3: In standard mode an accepted read places the oldest word on `dataOut` at the clock edge that accepts it, and words leave in the order they were written.
- R4: In standard mode the capacity is DEPTH words. A write while full and a read while empty are ignored: pointers and occupancy stay unchanged, and `dataOut` holds its value.
- R5: In fall-through mode a word written into an empty FIFO appears on `dataOut` with `rdAvail`=1 on the second edge after the write, without any read. Each accepted read presents the next word on the same edge that consumes the current one.
- R6: In fall-through mode the capacity is DEPTH+1 words, counting the output register. When that many words are held, `wrAvail`=0 and further writes are ignored.
- R7: `almostEmpty` is 1 when occupancy is at most AE_OFS in standard mode, or at most AE_OFS+1 in fall-through mode.
- R8: `almostFull` is 1 when occupancy is at least DEPTH-AF_OFS in standard mode, or at least DEPTH+1-AF_OFS in fall-through mode.
- R9: `halfFull` is 1 when occupancy exceeds DEPTH/2 in standard mode, or exceeds DEPTH/2+1 in fall-through mode.
- R10: All flags are registered. They reflect an accepted write or read on the same clock edge that updates occupancy, and occupancy changes by at most one word per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mRst | input | 1 | Synchronous master reset, active high |
| fwftSel | input | 1 | Read-mode select, sampled during reset |
| wrEn | input | 1 | Write request |
| dataIn | input | DATA_W | Write data |
| rdEn | input | 1 | Read request |
| dataOut | output | DATA_W | Output register |
| rdAvail | output | 1 | Standard: data stored; fall-through: output word valid |
| wrAvail | output | 1 | Space for another write |
| almostEmpty | output | 1 | Occupancy at or below the empty threshold |
| almostFull | output | 1 | Occupancy at or above the full threshold |
| halfFull | output | 1 | Occupancy above the half threshold |

## Verification
The assertions check four things on every cycle. The latched mode stays stable outside reset. Occupancy moves by at most one word. A full FIFO neither grows nor accepts a write. In standard mode an empty FIFO holds its output, and the flags stay consistent with one another at the empty and full extremes. The exact threshold values in each mode cannot be checked this way, and neither can word ordering, the two-edge fall-through latency, or the extra word of capacity. Only the bench scenarios can show these, because it drives known occupancy sequences and compares them against values derived from the requirements.

// File: rtl/dmfifo_pkg.sv
package dmfifo_pkg;
  // Strobes from control to datapath for one clock cycle
  typedef struct packed {
    logic push;   // store dataIn at the write pointer
    logic pop;    // move word at the read pointer into dataOut
  } fifoStrobes_t;
endpackage

// File: rtl/dmfifo_datapath.sv
module dmfifo_datapath #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic                      clk,
  input  logic                      mRst,
  input  dmfifo_pkg::fifoStrobes_t  strobes,
  input  logic [DATA_W-1:0]         dataIn,
  output logic [DATA_W-1:0]         dataOut
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;

  // storage array has no reset
  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= dataIn;
  end

  // pointers wrap naturally because DEPTH is a power of two
  always_ff @(posedge clk) begin
    if (mRst) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      dataOut <= '0;
    end else begin
      if (strobes.push) wrPtr <= wrPtr + 1'b1;
      if (strobes.pop) begin
        dataOut <= mem[rdPtr];
        rdPtr   <= rdPtr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmfifo_ctrl.sv
module dmfifo_ctrl #(
  parameter int DEPTH  = 8,
  parameter int AE_OFS = 2,
  parameter int AF_OFS = 2
) (
  input  logic                      clk,
  input  logic                      mRst,
  input  logic                      fwftSel,
  input  logic                      wrEn,
  input  logic                      rdEn,
  output dmfifo_pkg::fifoStrobes_t  strobes,
  output logic                      fwftMode,
  output logic [$clog2(DEPTH+2)-1:0] occCount,
  output logic                      rdAvail,
  output logic                      wrAvail,
  output logic                      almostEmpty,
  output logic                      almostFull,
  output logic                      halfFull
);
  localparam int OCC_W = $clog2(DEPTH+2);
  localparam logic [OCC_W-1:0] CAP_STD = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] AE_STD  = OCC_W'(AE_OFS);
  localparam logic [OCC_W-1:0] AF_STD  = OCC_W'(DEPTH - AF_OFS);
  localparam logic [OCC_W-1:0] HF_STD  = OCC_W'(DEPTH / 2);

  logic [OCC_W-1:0] memCount;
  logic             outValid;

  logic             pushOk, rdOk, popOk;
  logic [OCC_W-1:0] memNext, occNext;
  logic             outNext;
  logic [OCC_W-1:0] modeAdd;
  logic [OCC_W-1:0] capLim, aeLim, afLim, hfLim;

  // fall-through mode shifts every limit up by one word
  assign modeAdd = OCC_W'(fwftMode);
  assign capLim  = CAP_STD + modeAdd;
  assign aeLim   = AE_STD + modeAdd;
  assign afLim   = AF_STD + modeAdd;
  assign hfLim   = HF_STD + modeAdd;

  always_comb begin
    pushOk = wrEn && (memCount < CAP_STD);
    if (fwftMode) begin
      rdOk  = rdEn && outValid;
      popOk = (memCount != '0) && (!outValid || rdOk);
    end else begin
      rdOk  = rdEn && (memCount != '0);
      popOk = rdOk;
    end
    memNext = memCount + OCC_W'(pushOk) - OCC_W'(popOk);
    occNext = occCount + OCC_W'(pushOk) - OCC_W'(rdOk);
    if (!fwftMode)  outNext = 1'b0;
    else if (popOk) outNext = 1'b1;
    else if (rdOk)  outNext = 1'b0;
    else            outNext = outValid;
  end

  assign strobes.push = pushOk;
  assign strobes.pop  = popOk;

  always_ff @(posedge clk) begin
    if (mRst) begin
      fwftMode    <= fwftSel;
      memCount    <= '0;
      occCount    <= '0;
      outValid    <= 1'b0;
      rdAvail     <= 1'b0;
      wrAvail     <= 1'b1;
      almostEmpty <= 1'b1;
      almostFull  <= 1'b0;
      halfFull    <= 1'b0;
    end else begin
      memCount    <= memNext;
      occCount    <= occNext;
      outValid    <= outNext;
      rdAvail     <= fwftMode ? outNext : (memNext != '0);
      wrAvail     <= occNext < capLim;
      almostEmpty <= occNext <= aeLim;
      almostFull  <= occNext >= afLim;
      halfFull    <= occNext > hfLim;
    end
  end
endmodule

// File: rtl/dmfifo_top.sv
module dmfifo_top #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int AE_OFS = 2,
  parameter int AF_OFS = 2
) (
  input  logic              clk,
  input  logic              mRst,
  input  logic              fwftSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] dataOut,
  output logic              rdAvail,
  output logic              wrAvail,
  output logic              almostEmpty,
  output logic              almostFull,
  output logic              halfFull
);
  localparam int OCC_W = $clog2(DEPTH+2);

  dmfifo_pkg::fifoStrobes_t strobes;
  logic                     fwftMode;
  logic [OCC_W-1:0]         occCount;

  dmfifo_ctrl #(.DEPTH(DEPTH), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) u_ctrl (
    .clk(clk), .mRst(mRst), .fwftSel(fwftSel), .wrEn(wrEn), .rdEn(rdEn),
    .strobes(strobes), .fwftMode(fwftMode), .occCount(occCount),
    .rdAvail(rdAvail), .wrAvail(wrAvail), .almostEmpty(almostEmpty),
    .almostFull(almostFull), .halfFull(halfFull)
  );

  dmfifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .mRst(mRst), .strobes(strobes),
    .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/dmfifo_chk.sv
module dmfifo_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input logic                       clk,
  input logic                       mRst,
  input logic                       wrEn,
  input logic                       rdEn,
  input logic [DATA_W-1:0]          dataOut,
  input logic                       rdAvail,
  input logic                       wrAvail,
  input logic                       almostEmpty,
  input logic                       almostFull,
  input logic                       halfFull,
  input logic                       fwftMode,
  input logic [$clog2(DEPTH+2)-1:0] occCount
);
  // R1
  mode_fixed_chk: assert property (@(posedge clk) disable iff (mRst)
    $stable(fwftMode));

  // R10
  occ_step_chk: assert property (@(posedge clk) disable iff (mRst)
    (occCount != $past(occCount)) |->
      ((occCount - $past(occCount)) == 1 || ($past(occCount) - occCount) == 1));

  // R4
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (mRst)
    (!wrAvail && wrEn && !rdEn) |=> (occCount == $past(occCount)));

  // R6
  full_stays_full_chk: assert property (@(posedge clk) disable iff (mRst)
    (!wrAvail && !rdEn) |=> !wrAvail);

  // R4
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (mRst)
    (!fwftMode && !rdAvail && !wrEn) |=> $stable(dataOut));

  // R8
  full_flags_chk: assert property (@(posedge clk) disable iff (mRst)
    !wrAvail |-> (almostFull && halfFull));

  // R7
  empty_flags_chk: assert property (@(posedge clk) disable iff (mRst)
    (!fwftMode && !rdAvail) |-> almostEmpty);
endmodule

bind dmfifo_top dmfifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .mRst(mRst), .wrEn(wrEn), .rdEn(rdEn), .dataOut(dataOut),
  .rdAvail(rdAvail), .wrAvail(wrAvail), .almostEmpty(almostEmpty),
  .almostFull(almostFull), .halfFull(halfFull), .fwftMode(fwftMode),
  .occCount(occCount)
);

// File: tb/dmfifo_top_tb.sv
module dmfifo_top_tb;
  localparam int DW = 8;
  localparam int D  = 8;
  localparam int N  = 2;
  localparam int M  = 2;

  logic clk = 0;
  logic mRst = 1, fwftSel = 0, wrEn = 0, rdEn = 0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic rdAvail, wrAvail, almostEmpty, almostFull, halfFull;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dmfifo_top #(.DATA_W(DW), .DEPTH(D), .AE_OFS(N), .AF_OFS(M)) u_dut (
    .clk(clk), .mRst(mRst), .fwftSel(fwftSel), .wrEn(wrEn), .dataIn(dataIn),
    .rdEn(rdEn), .dataOut(dataOut), .rdAvail(rdAvail), .wrAvail(wrAvail),
    .almostEmpty(almostEmpty), .almostFull(almostFull), .halfFull(halfFull)
  );

  // standard-mode vectors: {wr, rd, din, flags{rdAvail,wrAvail,ae,af,hf}, chkData, expData}
  localparam int NV = 11;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h11, 5'b11100, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'h12, 5'b11100, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'h13, 5'b11000, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'h14, 5'b11000, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'h15, 5'b11001, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'h16, 5'b11011, 1'b0, 8'h00},
    {1'b1, 1'b1, 8'h17, 5'b11011, 1'b1, 8'h11},
    {1'b1, 1'b0, 8'h18, 5'b11011, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'h19, 5'b10011, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'h1A, 5'b10011, 1'b0, 8'h00},
    {1'b0, 1'b1, 8'h00, 5'b11011, 1'b1, 8'h12}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] flagsNow();
    return {rdAvail, wrAvail, almostEmpty, almostFull, halfFull};
  endfunction

  // expected {wrAvail, ae, af, hf} for an occupancy, from R6..R9
  function automatic logic [3:0] model(input int occ, input bit ft);
    int s = ft ? 1 : 0;
    return {occ < D + s, occ <= N + s, occ >= D - M + s, occ > D / 2 + s};
  endfunction

  task automatic step(input logic w, input logic r, input logic [DW-1:0] d);
    wrEn = w; rdEn = r; dataIn = d;
    @(posedge clk); #2;
    wrEn = 0; rdEn = 0;
  endtask

  task automatic doReset(input logic mode);
    mRst = 1; fwftSel = mode;
    repeat (2) @(posedge clk);
    #2 mRst = 0; fwftSel = ~mode;   // later changes must not matter (R1)
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // ---- standard mode ----
    doReset(1'b0);
    check("R2 reset flags", int'(flagsNow()), 5'b01100);
    check("R2 reset data", int'(dataOut), 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][23], VEC[i][22], VEC[i][21:14]);
      check($sformatf("R7 R8 R9 R10 flags vec %0d", i), int'(flagsNow()), int'(VEC[i][13:9]));
      if (VEC[i][8]) check($sformatf("R3 read data vec %0d", i), int'(dataOut), int'(VEC[i][7:0]));
    end

    // drain the seven remaining words in order (R3)
    for (int k = 0; k < 7; k++) begin
      step(1'b0, 1'b1, '0);
      check("R3 drain order", int'(dataOut), 8'h13 + k);
      check("R7 R8 R9 drain flags", int'(flagsNow()),
            int'({(6 - k) > 0, model(6 - k, 1'b0)}));
    end
    // read while empty ignored (R4)
    step(1'b0, 1'b1, '0);
    check("R4 empty read holds data", int'(dataOut), 8'h19);
    check("R4 empty read flags", int'(flagsNow()), 5'b01100);
    step(1'b1, 1'b0, 8'h77);
    step(1'b0, 1'b1, '0);
    check("R4 pointers unchanged by empty read", int'(dataOut), 8'h77);

    // ---- fall-through mode ----
    doReset(1'b1);
    check("R2 reset flags fwft", int'(flagsNow()), 5'b01100);
    check("R2 reset data fwft", int'(dataOut), 0);
    step(1'b1, 1'b0, 8'hA0);
    check("R5 not yet presented", int'(rdAvail), 0);
    check("R10 fwft flags occ1", int'(flagsNow() & 5'b01111), int'(model(1, 1'b1)));
    step(1'b0, 1'b0, '0);
    check("R5 word presented without read", int'(rdAvail), 1);
    check("R5 presented data", int'(dataOut), 8'hA0);
    for (int i = 1; i <= 8; i++) begin
      step(1'b1, 1'b0, 8'hA0 + i);
      check($sformatf("R7 R8 R9 fwft fill occ %0d", i + 1),
            int'(flagsNow() & 5'b01111), int'(model(i + 1, 1'b1)));
    end
    check("R6 full at DEPTH+1", int'(wrAvail), 0);
    step(1'b1, 1'b0, 8'hFF);
    check("R6 write while full ignored", int'(flagsNow()), int'({1'b1, model(9, 1'b1)}));
    for (int i = 1; i <= 8; i++) begin
      step(1'b0, 1'b1, '0);
      check("R5 next word presented on read", int'(dataOut), 8'hA0 + i);
      check("R7 R8 R9 fwft drain flags", int'(flagsNow()),
            int'({1'b1, model(9 - i, 1'b1)}));
    end
    step(1'b0, 1'b1, '0);
    check("R5 empty after last read", int'(flagsNow()), int'({1'b0, model(0, 1'b1)}));
    check("R6 last word stays on output", int'(dataOut), 8'hA8);

    // fwftSel is now 0 without a reset: mode must stay fall-through (R1)
    step(1'b1, 1'b0, 8'h5A);
    step(1'b0, 1'b0, '0);
    check("R1 mode kept after select change", int'(rdAvail), 1);
    check("R1 data fell through", int'(dataOut), 8'h5A);

    finishRun();
  end
endmodule